// File: doc/BRIEF.md
# Paired-Frame UART Receive Buffer

This block sits behind a UART receive shifter and collects finished frames two at a time. Each frame arrives as one data byte with a single-cycle done strobe. The byte is written into one of two holding slots. When the second slot of a pair is filled, the block marks the pair as pending and raises one interrupt pulse. The host services a pair by reading the status, which clears the overrun flag, and then reading the pair, which clears the pending state.

A frame can finish while a pair is still pending. This is an overrun. The new byte is written into both slots, no interrupt is raised, and a sticky overrun flag is set. The overrun consumes the pending pair, and the next slot to fill is the second one. The following frame therefore completes a pair made of the overrunning byte and the new one, and that completion does raise the interrupt. A new pair completing never clears the overrun flag. Only a status read clears it.

Top module: `urxp_pair_buffer`

## Requirements
- R1: A synchronous active-low reset clears both slots to zero, the overrun flag, the pending state and the interrupt. It also points the next write at the first slot.
- R2: A frame that arrives with no pair pending and the first slot selected is written to the first slot, bits [DATA_W-1:0] of `pair_data`. No interrupt is raised, and the second slot keeps its value.
- R3: A frame that arrives with no pair pending and the second slot selected is written to bits [2*DATA_W-1:DATA_W]. It sets the pending state, and `pair_irq` is high in the cycle after the done strobe.
- R4: A frame that arrives while a pair is pending, with no pair read in the same cycle, is an overrun. Its byte is written into both slots, the overrun flag is set, no interrupt is raised and the pending state is cleared.
- R5: The first frame after an overrun is written to the second slot. It completes the pair {new byte, overrunning byte} and raises the interrupt.
- R6: The overrun flag stays set across later pair completions and across pair reads. It is cleared only by a status read.
- R7: A status read clears the overrun flag. If a status read and an overrun fall in the same cycle, the flag ends up set.
- R8: A pair read clears the pending state. If a pair read and a frame done fall in the same cycle, the read counts as servicing the pair first, so that frame is not an overrun and is placed by the slot selector.
- R9: `pair_data` always holds {second slot, first slot}, with the first frame of a pair in the low byte.
- R10: `pair_irq` is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_done | input | 1 | One-cycle strobe from the shifter: a frame is complete |
| frame_data | input | DATA_W | Byte of the completed frame |
| status_rd | input | 1 | Host status read strobe; clears the overrun flag |
| pair_rd | input | 1 | Host pair read strobe; clears the pending state |
| pair_data | output | 2*DATA_W | {second slot, first slot} |
| ovr_flag | output | 1 | Sticky overrun flag |
| pair_pending | output | 1 | A completed pair awaits service |
| pair_irq | output | 1 | One-cycle pair-complete interrupt pulse |

## Verification
Two pairs of events can land on the same clock edge. The first is a host pair read together with a frame done while a pair is pending. The read must win, so the frame is placed normally and no overrun is recorded. The second is a host status read together with an overrunning frame. Here the set must win, so the flag stays at 1. The bench drives both strobes in one vector row and then judges the slots, the flag, the pending state and the interrupt one edge later against values worked out from R7 and R8.

// File: rtl/urxp_pkg.sv
// Package: shared types for the paired-frame receive buffer.
// Assumes exactly two holding slots.
package urxp_pkg;
    localparam int SLOT_COUNT = 2;

    // Which slot(s) the current frame is written to.
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_LOW  = 2'd1,
        WR_HIGH = 2'd2,
        WR_BOTH = 2'd3
    } slot_wr_e;
endpackage

// File: rtl/urxp_pair_ctrl.sv
// Module: urxp_pair_ctrl
// Decides where each finished frame goes. It tracks the slot selector and the
// pending pair, and produces the pair-complete pulse and the overrun event.
// Assumes frame_done is a one-cycle strobe. A pair read in the same cycle as
// frame_done is treated as servicing the pending pair first.
module urxp_pair_ctrl
    import urxp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_done,
    input  logic     pair_rd,
    output slot_wr_e slot_wr,
    output logic     ovr_event,
    output logic     pending,
    output logic     irq
);
    logic sel_high;
    logic pend_eff;
    logic completes;

    // Work out the write target and the events for this cycle.
    always_comb begin
        pend_eff  = pending & ~pair_rd;
        slot_wr   = WR_NONE;
        ovr_event = 1'b0;
        completes = 1'b0;
        if (frame_done) begin
            if (pend_eff) begin
                slot_wr   = WR_BOTH;
                ovr_event = 1'b1;
            end else if (sel_high) begin
                slot_wr   = WR_HIGH;
                completes = 1'b1;
            end else begin
                slot_wr   = WR_LOW;
            end
        end
    end

    // Slot selector: an overrun forces the next frame into the high slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_high <= 1'b0;
        else if (slot_wr == WR_BOTH || slot_wr == WR_LOW)
            sel_high <= 1'b1;
        else if (slot_wr == WR_HIGH)
            sel_high <= 1'b0;
    end

    // Pending state: set by a completed pair, cleared by a read or an overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else
            pending <= completes | (pend_eff & ~frame_done);
    end

    // Interrupt pulse in the cycle after a pair-completing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= completes;
    end

    // R10: the interrupt never lasts two cycles.
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3: an interrupt always comes with a fresh pending pair.
    p_irq_with_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);

    // R8: a read with no frame leaves nothing pending.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_rd && !frame_done) |=> !pending);

    // R4: an overrun leaves no pair pending and raises no interrupt.
    p_ovr_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pending && !pair_rd) |=> (!pending && !irq));
endmodule

// File: rtl/urxp_slot_store.sv
// Module: urxp_slot_store
// Two holding slots of DATA_W bits, written by the slot_wr command.
// Assumes the command is decoded by urxp_pair_ctrl in the same cycle.
module urxp_slot_store
    import urxp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  slot_wr_e                     slot_wr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [SLOT_COUNT*DATA_W-1:0] pair_data
);
    localparam int PAIR_W = SLOT_COUNT * DATA_W;

    logic [DATA_W-1:0] slot_q [SLOT_COUNT];

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        logic wr_en;

        // Write enable: a dual write, or a single write aimed at this slot.
        always_comb begin
            wr_en = (slot_wr == WR_BOTH) ||
                    (s == 0 && slot_wr == WR_LOW) ||
                    (s == 1 && slot_wr == WR_HIGH);
        end

        // Slot register: cleared on reset, loaded when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en)
                slot_q[s] <= wr_data;
        end

        assign pair_data[s*DATA_W +: DATA_W] = slot_q[s];
    end

    // R4: after a dual write both slots hold the same byte.
    p_dual_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_wr == WR_BOTH) |=> (pair_data[DATA_W-1:0] == pair_data[PAIR_W-1:DATA_W]));

    // R2: a low write leaves the high slot untouched.
    p_low_keeps_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_wr == WR_LOW) |=> $stable(pair_data[PAIR_W-1:DATA_W]));
endmodule

// File: rtl/urxp_ovr_flag.sv
// Module: urxp_ovr_flag
// Sticky overrun flag. It is set by an overrun event and cleared by a status
// read. If both happen in the same cycle, the set wins.
module urxp_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_event,
    input  logic status_rd,
    output logic flag
);
    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (ovr_event)
            flag <= 1'b1;
        else if (status_rd)
            flag <= 1'b0;
    end

    // R6: without a status read the flag never drops.
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !status_rd) |=> flag);

    // R7: an overrun event always leaves the flag set.
    p_ovr_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> flag);
endmodule

// File: rtl/urxp_pair_buffer.sv
// Module: urxp_pair_buffer (top)
// Groups received frames into pairs and raises one interrupt per pair.
// Overruns are detected and recorded in a sticky flag.
// Assumes frame_done, status_rd and pair_rd are single-cycle strobes.
module urxp_pair_buffer
    import urxp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_done,
    input  logic [DATA_W-1:0]     frame_data,
    input  logic                  status_rd,
    input  logic                  pair_rd,
    output logic [2*DATA_W-1:0]   pair_data,
    output logic                  ovr_flag,
    output logic                  pair_pending,
    output logic                  pair_irq
);
    slot_wr_e slot_wr;
    logic     ovr_event;

    urxp_pair_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .pair_rd    (pair_rd),
        .slot_wr    (slot_wr),
        .ovr_event  (ovr_event),
        .pending    (pair_pending),
        .irq        (pair_irq)
    );

    urxp_slot_store #(.DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_wr   (slot_wr),
        .wr_data   (frame_data),
        .pair_data (pair_data)
    );

    urxp_ovr_flag flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_event (ovr_event),
        .status_rd (status_rd),
        .flag      (ovr_flag)
    );

    // R4: an overrun at the ports sets the flag and copies the byte into both slots.
    p_port_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pair_pending && !pair_rd) |=>
        (ovr_flag && pair_data[DATA_W-1:0] == $past(frame_data)
                  && pair_data[2*DATA_W-1:DATA_W] == $past(frame_data)));

    // R8: a read together with a frame is never counted as an overrun.
    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pair_rd && !ovr_flag && !status_rd) |=> !ovr_flag);
endmodule

// File: tb/urxp_pair_buffer_tb_top.sv
module urxp_pair_buffer_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 1'b0;
    logic [DW-1:0] frame_data = '0;
    logic          status_rd = 1'b0;
    logic          pair_rd = 1'b0;
    logic [2*DW-1:0] pair_data;
    logic          ovr_flag;
    logic          pair_pending;
    logic          pair_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    urxp_pair_buffer #(.DATA_W(DW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .frame_data   (frame_data),
        .status_rd    (status_rd),
        .pair_rd      (pair_rd),
        .pair_data    (pair_data),
        .ovr_flag     (ovr_flag),
        .pair_pending (pair_pending),
        .pair_irq     (pair_irq)
    );

    // Row: req[33:30] ops{prd,srd,frm}[29:27] data[26:19] irq[18] ovr[17] pend[16] pair[15:0]
    localparam int NV = 22;
    localparam logic [33:0] VEC [NV] = '{
        {4'd2,  3'b001, 8'hA1, 1'b0, 1'b0, 1'b0, 16'h00A1}, // R2 first slot
        {4'd3,  3'b001, 8'hA2, 1'b1, 1'b0, 1'b1, 16'hA2A1}, // R3, R9 pair complete
        {4'd8,  3'b100, 8'h00, 1'b0, 1'b0, 1'b0, 16'hA2A1}, // R8 pair read
        {4'd2,  3'b001, 8'hB1, 1'b0, 1'b0, 1'b0, 16'hA2B1}, // R2 high slot kept
        {4'd3,  3'b001, 8'hB2, 1'b1, 1'b0, 1'b1, 16'hB2B1}, // R3
        {4'd4,  3'b001, 8'hB3, 1'b0, 1'b1, 1'b0, 16'hB3B3}, // R4 overrun
        {4'd7,  3'b010, 8'h00, 1'b0, 1'b0, 1'b0, 16'hB3B3}, // R7 status clears
        {4'd8,  3'b100, 8'h00, 1'b0, 1'b0, 1'b0, 16'hB3B3}, // R8 read
        {4'd5,  3'b001, 8'hB4, 1'b1, 1'b0, 1'b1, 16'hB4B3}, // R5 serviced then 4th
        {4'd8,  3'b100, 8'h00, 1'b0, 1'b0, 1'b0, 16'hB4B3}, // R8
        {4'd2,  3'b001, 8'hC1, 1'b0, 1'b0, 1'b0, 16'hB4C1}, // R2
        {4'd3,  3'b001, 8'hC2, 1'b1, 1'b0, 1'b1, 16'hC2C1}, // R3
        {4'd4,  3'b001, 8'hC3, 1'b0, 1'b1, 1'b0, 16'hC3C3}, // R4
        {4'd5,  3'b001, 8'hC4, 1'b1, 1'b1, 1'b1, 16'hC4C3}, // R5, R6 flag stays
        {4'd6,  3'b100, 8'h00, 1'b0, 1'b1, 1'b0, 16'hC4C3}, // R6 read keeps flag
        {4'd7,  3'b010, 8'h00, 1'b0, 1'b0, 1'b0, 16'hC4C3}, // R7
        {4'd2,  3'b001, 8'hD1, 1'b0, 1'b0, 1'b0, 16'hC4D1}, // R2
        {4'd3,  3'b001, 8'hD2, 1'b1, 1'b0, 1'b1, 16'hD2D1}, // R3
        {4'd8,  3'b101, 8'hD3, 1'b0, 1'b0, 1'b0, 16'hD2D3}, // R8 read+frame
        {4'd3,  3'b001, 8'hD4, 1'b1, 1'b0, 1'b1, 16'hD4D3}, // R3
        {4'd7,  3'b011, 8'hE1, 1'b0, 1'b1, 1'b0, 16'hE1E1}, // R7 status+overrun
        {4'd10, 3'b000, 8'h00, 1'b0, 1'b1, 1'b0, 16'hE1E1}  // R10 pulse ended
    };

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got irq/ovr/pend/pair=%h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] ops, input logic [7:0] d);
        frame_done = ops[0];
        status_rd  = ops[1];
        pair_rd    = ops[2];
        frame_data = d;
        @(negedge clk);
        frame_done = 1'b0;
        status_rd  = 1'b0;
        pair_rd    = 1'b0;
    endtask

    function automatic logic [18:0] obs();
        return {pair_irq, ovr_flag, pair_pending, pair_data};
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", obs(), 19'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][29:27], VEC[i][26:19]);
            check($sformatf("R%0d row %0d", VEC[i][33:30], i), obs(), VEC[i][18:0]);
        end

        // R1: reset in the middle of a state with the flag set.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset", obs(), 19'h0);

        // R1: the selector was reset, so the next frame goes to the low slot.
        apply(3'b001, 8'h5A);
        check("R1 selector", obs(), {3'b000, 16'h005A});

        // R10: the pulse is high for one cycle only.
        apply(3'b001, 8'h6B);
        check("R10 pulse high", obs(), {3'b101, 16'h6B5A});
        @(negedge clk);
        check("R10 pulse low", obs(), {3'b001, 16'h6B5A});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule